// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Chain

A row of interrupt source nodes shares one request line to the processor and one acknowledge that passes from node to node. Each node latches a request pulse from its device into a pending flag. The shared request output is the OR of all pending flags.

When the processor raises its acknowledge, the acknowledge enters node 0. A node that is not pending passes it on to the next node. The first pending node keeps the acknowledge, so position alone sets priority: node 0 is highest.

The winning node does three things at one clock edge. It places its programmed vector code on the vector bus, raises the valid strobe and clears its pending flag. The processor reads the code while its acknowledge stays high. If no node is pending when the acknowledge rises, a one-cycle spurious flag reports that nobody answered.

Top module: `irq_ack_chain`

## Requirements
- R1: `irq_o` is high exactly when at least one node is pending. A one-cycle pulse on `req_i[k]` makes node k pending from the clock edge that samples it.
- R2: The acknowledge enters node 0 and passes to node k+1 only when node k is not pending. The lowest-numbered pending node wins.
- R3: At most one node claims the acknowledge. The winner k drives `vec_o = vec_cfg_i[k*8 +: 8]` with `vec_valid_o` high.
- R4: The winner is chosen only at the first edge that samples `ack_i` high after it was low. The vector and valid appear after that edge and stay while `ack_i` stays high. Both clear at the first edge that samples `ack_i` low.
- R5: The winner's pending flag clears at the same edge at which it starts driving its vector. Nodes that lost stay pending.
- R6: A request that arrives while `ack_i` is already high does not take the acknowledge from the node that claimed it. It stays pending and wins a later acknowledge.
- R7: While no node is claiming, `vec_o` is 0 and `vec_valid_o` is low.
- R8: If `ack_i` rises while no node is pending, `spurious_o` is high for exactly one cycle and `vec_valid_o` stays low.
- R9: Asynchronous active-low reset clears all pending flags and claims. `irq_o`, `vec_valid_o`, `vec_o` and `spurious_o` are all 0 after reset.
- R10: If a node wins in the same cycle that its `req_i` pulses, it stays pending. `irq_o` stays high and the node wins the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_NODES | Per-node request pulse |
| vec_cfg_i | input | N_NODES*VEC_W | Vector codes; node k uses slice [k*VEC_W +: VEC_W] |
| ack_i | input | 1 | Acknowledge level from the processor |
| irq_o | output | 1 | Shared interrupt request |
| vec_o | output | VEC_W | Vector code of the claiming node, 0 when none |
| vec_valid_o | output | 1 | A node is driving `vec_o` |
| spurious_o | output | 1 | Acknowledge rose with no pending node |

## Verification
Every result is due one clock edge after the stimulus that causes it:
- `irq_o` follows one edge after a request pulse.
- The vector, the valid strobe, the drop of `irq_o` and the spurious pulse all follow the edge that first samples `ack_i` high.
- The vector and valid clear one edge after `ack_i` is sampled low.

The bench changes inputs on the falling edge and checks after the next falling edge, so each check lands one rising edge after its stimulus. The spurious flag is also checked one further cycle later to confirm that it lasts exactly one cycle.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  parameter int unsigned DEF_NODES = 4;
  parameter int unsigned DEF_VEC_W = 8;
endpackage

// File: rtl/irq_chain_edge.sv
module irq_chain_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_lvl_i,
  input  logic ack_rise_i,
  input  logic pass_i,
  output logic pass_o,
  output logic pending_o,
  output logic claim_o
);
  logic pending_q, claim_q, grant;

  assign grant  = pass_i & pending_q;
  assign pass_o = pass_i & ~pending_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pending_q <= 1'b0;
      claim_q   <= 1'b0;
    end else begin
      // a new request in the claim cycle re-arms the node
      pending_q <= (pending_q & ~(ack_rise_i & grant)) | req_i;
      // claim decided only on the acknowledge rising edge
      claim_q   <= ack_rise_i ? grant : (claim_q & ack_lvl_i);
    end

  assign pending_o = pending_q;
  assign claim_o   = claim_q;
endmodule

// File: rtl/irq_chain_vmux.sv
module irq_chain_vmux #(
  parameter int unsigned N_NODES = 4,
  parameter int unsigned VEC_W   = 8
) (
  input  logic [N_NODES-1:0]       sel_i,
  input  logic [N_NODES*VEC_W-1:0] data_i,
  output logic [VEC_W-1:0]         data_o
);
  always_comb begin
    data_o = '0;
    for (int k = 0; k < N_NODES; k++)
      data_o |= data_i[k*VEC_W +: VEC_W] & {VEC_W{sel_i[k]}};
  end
endmodule

// File: rtl/irq_ack_chain.sv
module irq_ack_chain #(
  parameter int unsigned N_NODES = irq_chain_pkg::DEF_NODES,
  parameter int unsigned VEC_W   = irq_chain_pkg::DEF_VEC_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_NODES-1:0]         req_i,
  input  logic [N_NODES*VEC_W-1:0]   vec_cfg_i,
  input  logic                       ack_i,
  output logic                       irq_o,
  output logic [VEC_W-1:0]           vec_o,
  output logic                       vec_valid_o,
  output logic                       spurious_o
);
  logic               ack_rise;
  logic [N_NODES:0]   pass_w;
  logic [N_NODES-1:0] pending_w, claim_w;
  logic               spurious_q;

  irq_chain_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ack_i),
    .rise_o (ack_rise)
  );

  assign pass_w[0] = 1'b1;

  for (genvar k = 0; k < N_NODES; k++) begin : g_node
    irq_chain_node u_node (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_i[k]),
      .ack_lvl_i  (ack_i),
      .ack_rise_i (ack_rise),
      .pass_i     (pass_w[k]),
      .pass_o     (pass_w[k+1]),
      .pending_o  (pending_w[k]),
      .claim_o    (claim_w[k])
    );
  end

  irq_chain_vmux #(.N_NODES(N_NODES), .VEC_W(VEC_W)) u_vmux (
    .sel_i  (claim_w),
    .data_i (vec_cfg_i),
    .data_o (vec_o)
  );

  // acknowledge fell off the end of the chain
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) spurious_q <= 1'b0;
    else         spurious_q <= ack_rise & pass_w[N_NODES];

  assign irq_o       = |pending_w;
  assign vec_valid_o = |claim_w;
  assign spurious_o  = spurious_q;
endmodule

// File: rtl/irq_ack_chain_chk.sv
module irq_ack_chain_chk #(
  parameter int unsigned N_NODES = 4,
  parameter int unsigned VEC_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic [N_NODES-1:0] claim_w,
  input logic [VEC_W-1:0]   vec_o,
  input logic               vec_valid_o,
  input logic               spurious_o
);
  p_onehot_claim_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_w));
  p_valid_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_valid_o) |-> $past(ack_i));
  p_clear_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_i) |=> !vec_valid_o);
  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> vec_o == '0);
  p_spur_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spurious_o |=> !spurious_o);
  p_spur_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spurious_o |-> !vec_valid_o);
endmodule

bind irq_ack_chain irq_ack_chain_chk #(.N_NODES(N_NODES), .VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_i       (ack_i),
  .claim_w     (claim_w),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .spurious_o  (spurious_o)
);

// File: tb/irq_ack_chain_tb_top.sv
module irq_ack_chain_tb_top;
  localparam int N = 4;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   req = '0;
  logic [N*W-1:0] cfg;
  logic           ack = 1'b0;
  logic           irq, vld, spur;
  logic [W-1:0]   vec;
  int             checks = 0;
  int             errors = 0;

  always #5 clk = ~clk;

  irq_ack_chain #(.N_NODES(N), .VEC_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vec_cfg_i(cfg), .ack_i(ack),
    .irq_o(irq), .vec_o(vec), .vec_valid_o(vld), .spurious_o(spur)
  );

  function automatic logic [W-1:0] code_of(int k);
    return W'(8'h30 + 8'h11 * k);
  endfunction

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  task automatic edge1; @(negedge clk); endtask

  task automatic pulse_req(logic [N-1:0] m);
    req = m; edge1(); req = '0;
  endtask

  task automatic ack_on;  ack = 1'b1; edge1(); endtask
  task automatic ack_off; ack = 1'b0; edge1(); endtask

  task automatic t_reset;
    chk("R9 irq", irq, 0);
    chk("R9 valid", vld, 0);
    chk("R9 vec", vec, 0);
    chk("R9 spurious", spur, 0);
  endtask

  task automatic t_single;
    pulse_req(4'b0100);
    chk("R1 irq after req", irq, 1);
    chk("R7 vec idle", vec, 0);
    ack_on();
    chk("R2 passes to node2 valid", vld, 1);
    chk("R3 vec node2", vec, code_of(2));
    chk("R5 irq dropped with vector", irq, 0);
    edge1(); edge1();
    chk("R4 vec held", vec, code_of(2));
    chk("R4 valid held", vld, 1);
    ack_off();
    chk("R4 valid cleared", vld, 0);
    chk("R7 vec zero", vec, 0);
  endtask

  task automatic t_priority;
    pulse_req(4'b1010);
    ack_on();
    chk("R2 lowest index wins", vec, code_of(1));
    chk("R5 loser still pending", irq, 1);
    ack_off();
    ack_on();
    chk("R2 next node served", vec, code_of(3));
    chk("R1 irq low all served", irq, 0);
    ack_off();
  endtask

  task automatic t_late;
    pulse_req(4'b0100);
    ack_on();
    pulse_req(4'b0001);
    chk("R6 claim not stolen", vec, code_of(2));
    chk("R6 late req pending", irq, 1);
    edge1();
    chk("R6 claim still held", vec, code_of(2));
    ack_off();
    ack_on();
    chk("R6 late req served", vec, code_of(0));
    ack_off();
  endtask

  task automatic t_spurious;
    ack_on();
    chk("R8 spurious pulse", spur, 1);
    chk("R8 no valid", vld, 0);
    edge1();
    chk("R8 spurious one cycle", spur, 0);
    ack_off();
  endtask

  task automatic t_rearm;
    pulse_req(4'b0010);
    req = 4'b0010; ack = 1'b1; edge1(); req = '0;
    chk("R10 claimed", vec, code_of(1));
    chk("R10 still pending", irq, 1);
    ack_off();
    ack_on();
    chk("R10 served again", vec, code_of(1));
    chk("R10 irq low", irq, 0);
    ack_off();
  endtask

  task automatic t_reprogram;
    cfg[0 +: W] = 8'hE7;
    pulse_req(4'b1001);
    ack_on();
    chk("R3 reprogrammed code node0", vec, 8'hE7);
    ack_off();
    ack_on();
    chk("R3 node3 code", vec, code_of(3));
    ack_off();
  endtask

  initial begin
    for (int k = 0; k < N; k++) cfg[k*W +: W] = code_of(k);
    edge1(); edge1();
    t_reset();
    rst_n = 1'b1;
    edge1();
    t_reset();
    t_single();
    t_priority();
    t_late();
    t_spurious();
    t_rearm();
    t_reprogram();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule